// File: doc/BRIEF.md
# Protocol Control Microsequencer

This block steps through a byte-wide microprogram and turns it into single-cycle control pulses for the rest of a token-passing network controller. It runs from one input clock. The program counter steps once per clock. Instructions execute on every second clock, so one execute period is two clocks. In the first clock of a period the sequencer latches the opcode byte into an opcode register. In the second clock it latches the immediate byte into an immediate register and acts on the instruction. The microprogram comes in as a packed parameter image. It is held in a synchronous-read ROM that an FPGA can map to block RAM.

There are three instruction classes. An action emits a one-hot control pulse. A wait freezes the program counter for a number of execute periods. A jump reloads the program counter from a target carried in the instruction. A reconfiguration timeout input can interrupt the sequencer in any state. It sends the sequencer back to address zero and raises a sticky flag, which a clear strobe drops. The network datapath, the register file and the host bus lie outside this block.

Top module: `ring_useq`

## Requirements
- R1: A synchronous active-high reset clears the program counter, both instruction registers (so `imm_o` reads 0), the control vector, the wait indication and the reconfiguration flag. Once reset is released, the first clock edge fetches the opcode at address 0.
- R2: Outside a wait, the program counter rises by one on every clock edge. The first edge of each two-clock period latches the opcode byte and the second latches the immediate byte. ROM address `a` occupies bits `[8a+7:8a]` of `ROM_IMAGE`.
- R3: Opcode classes: bit 7 set is an action, `01` in bits 7:6 is a jump, and `00` in bits 7:6 is a wait.
- R4: For an action, the clock after the immediate fetch shows on `ctrl_o` only bit `op[5:0]`, for exactly one clock. A select of `CTRL_W` or more gives an all-zero vector. `imm_o` shows the immediate byte of the latest instruction.
- R5: A wait with immediate N holds the program counter and drives `wait_o` high for 2*max(N,1) clocks, and `ctrl_o` stays zero throughout. Fetching resumes at the address after the wait instruction.
- R6: A jump loads the program counter with the 10-bit target {op[1:0], immediate}. The next fetch comes from that address.
- R7: A jump target at or beyond `ROM_DEPTH` loads address 0.
- R8: Stepping past address `ROM_DEPTH-1` wraps the program counter to 0.
- R9: With `recon_i` high at a clock edge, the program counter becomes 0 and the flag is set. Any wait is cancelled, no control pulse follows, and the next edge fetches an opcode.
- R10: The reconfiguration flag stays set until an edge with `flag_clr_i` high and `recon_i` low. When both are high, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the program counter step rate |
| rst | input | 1 | Synchronous active-high reset |
| recon_i | input | 1 | Reconfiguration timeout interrupt |
| flag_clr_i | input | 1 | Clear strobe for the reconfiguration flag |
| ctrl_o | output | CTRL_W | One-clock one-hot control pulse from an action |
| imm_o | output | 8 | Immediate register contents |
| pc_o | output | PC_W | Program counter |
| wait_o | output | 1 | High while a wait holds the program counter |
| recon_flag_o | output | 1 | Sticky reconfiguration flag |

## Verification
The main program runs eight actions in sequence, with selects 0 through 7 and distinct immediates. Any error in opcode decode, select-to-bit mapping or the two-clock cadence therefore shows up as a wrong bit or a wrong immediate. The program also has waits of zero and three periods, so the single-period floor for N=0 can be told apart from a counter that scales with N. A jump into the high page exercises the target concatenation (R6), and the fall-through from the last two addresses exercises the wrap (R8). A second, sixteen-entry instance executes an out-of-range select and a jump beyond its depth, which checks R7 and the zero-vector case of R4. Reconfiguration pulses are applied in the middle of a wait, alone, and together with the clear strobe, which separates a cancelled wait and a set-wins flag from a flag that merely toggles.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int OP_W    = 8;
  localparam int IMM_W   = 8;
  localparam int SEL_W   = 6;
  localparam int TGT_W   = 2 + IMM_W;

  typedef enum logic [1:0] {
    CLS_WAIT = 2'd0,
    CLS_JUMP = 2'd1,
    CLS_ACT  = 2'd2
  } op_cls_e;

  function automatic op_cls_e op_class(input logic [OP_W-1:0] op);
    if (op[7])      return CLS_ACT;
    else if (op[6]) return CLS_JUMP;
    else            return CLS_WAIT;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int DEPTH = 544,
  parameter int AW    = 10,
  parameter logic [DEPTH*8-1:0] IMAGE = '0
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    data_o
);

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = IMAGE[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    data_o <= mem[addr_i];
  end

endmodule

// File: rtl/useq_phase.sv
module useq_phase (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic exec_en_o
);

  logic ph_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) ph_q <= 1'b0;
    else                  ph_q <= ~ph_q;
  end

  assign exec_en_o = ph_q;

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !restart_i |=> (ph_q != $past(ph_q)));

  // R9
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !ph_q);

endmodule

// File: rtl/useq_wait.sv
module useq_wait #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          exec_en_i,
  output logic          busy_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i)          cnt_q <= '0;
    else if (start_i)            cnt_q <= (count_i == '0) ? CW'(1) : count_i;
    else if (exec_en_i && busy_o) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R5
  wait_idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_o);

  // R5
  wait_end_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(exec_en_i || clear_i));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int CTRL_W = 8,
  parameter int SW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic [SW-1:0]     sel_i,
  output logic [CTRL_W-1:0] ctrl_o
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] onehot;

  always_comb begin
    onehot = '0;
    for (int b = 0; b < CTRL_W; b++) begin
      if (int'(sel_i) == b) onehot[b] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (fire_i) ctrl_q <= onehot;
    else             ctrl_q <= '0;
  end

  assign ctrl_o = ctrl_q;

  // R4
  ctrl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl_q));

  // R4
  ctrl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q != '0) |=> (ctrl_q == '0));

endmodule

// File: rtl/ring_useq.sv
module ring_useq
  import useq_pkg::*;
#(
  parameter int ROM_DEPTH = 544,
  parameter int CTRL_W    = 8,
  parameter logic [ROM_DEPTH*8-1:0] ROM_IMAGE = '0,
  localparam int PC_W = $clog2(ROM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              recon_i,
  input  logic              flag_clr_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              wait_o,
  output logic              recon_flag_o
);

  logic [PC_W-1:0]  pc_q, pc_nxt, pc_inc, rd_addr;
  logic [OP_W-1:0]  op_q;
  logic [IMM_W-1:0] imm_q;
  logic [7:0]       rom_q;
  logic [TGT_W-1:0] tgt;
  logic             flag_q;
  logic             exec_en, busy;
  logic             fetch_op, exec_now;
  logic             wait_start, act_fire;
  op_cls_e          cls;

  useq_rom #(.DEPTH(ROM_DEPTH), .AW(PC_W), .IMAGE(ROM_IMAGE)) rom_i (
    .clk    (clk),
    .addr_i (rd_addr),
    .data_o (rom_q)
  );

  useq_phase phase_i (
    .clk       (clk),
    .rst       (rst),
    .restart_i (recon_i),
    .exec_en_o (exec_en)
  );

  useq_wait #(.CW(IMM_W)) wait_i (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (recon_i),
    .start_i   (wait_start),
    .count_i   (rom_q),
    .exec_en_i (exec_en),
    .busy_o    (busy)
  );

  useq_ctrl #(.CTRL_W(CTRL_W), .SW(SEL_W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .fire_i (act_fire),
    .sel_i  (op_q[SEL_W-1:0]),
    .ctrl_o (ctrl_o)
  );

  assign cls        = op_class(op_q);
  assign fetch_op   = !exec_en && !busy && !recon_i;
  assign exec_now   = exec_en && !busy && !recon_i;
  assign wait_start = exec_now && (cls == CLS_WAIT);
  assign act_fire   = exec_now && (cls == CLS_ACT);
  assign tgt        = {op_q[1:0], rom_q};
  assign pc_inc     = (pc_q == PC_W'(ROM_DEPTH - 1)) ? '0 : pc_q + 1'b1;

  always_comb begin
    pc_nxt = pc_q;
    if (recon_i) begin
      pc_nxt = '0;
    end else if (!busy) begin
      if (exec_en && cls == CLS_JUMP)
        pc_nxt = (int'(tgt) < ROM_DEPTH) ? tgt[PC_W-1:0] : '0;
      else
        pc_nxt = pc_inc;
    end
  end

  assign rd_addr = rst ? '0 : pc_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      op_q   <= '0;
      imm_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      pc_q <= pc_nxt;
      if (fetch_op) op_q  <= rom_q;
      if (exec_now) imm_q <= rom_q;
      if (recon_i)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign imm_o        = imm_q;
  assign pc_o         = pc_q;
  assign wait_o       = busy;
  assign recon_flag_o = flag_q;

  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !recon_i) |=> (pc_q == $past(pc_q)));

  // R5
  quiet_wait_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (ctrl_o == '0));

  // R9
  recon_pc_chk: assert property (@(posedge clk) disable iff (rst)
    recon_i |=> (pc_q == '0 && flag_q && !busy && ctrl_o == '0));

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i && !recon_i) |=> !flag_q);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_clr_i && !recon_i) |=> (flag_q == $past(flag_q)));

  // R2
  op_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_op |=> $stable(op_q));

endmodule

// File: tb/ring_useq_tb_top.sv
module ring_useq_tb_top;

  localparam int CLK_P  = 10;
  localparam int DEPTH  = 544;
  localparam int SDEPTH = 16;

  function automatic logic [DEPTH*8-1:0] build_main();
    logic [DEPTH*8-1:0] img;
    img = '0;
    for (int k = 0; k < 8; k++) begin
      img[(2*k)*8 +: 8]   = 8'h80 | 8'(k);
      img[(2*k+1)*8 +: 8] = 8'h10 + 8'(k);
    end
    img[16*8 +: 8]  = 8'h00; img[17*8 +: 8]  = 8'h00;
    img[18*8 +: 8]  = 8'h00; img[19*8 +: 8]  = 8'h03;
    img[20*8 +: 8]  = 8'h42; img[21*8 +: 8]  = 8'd28;
    img[540*8 +: 8] = 8'h87; img[541*8 +: 8] = 8'h77;
    img[542*8 +: 8] = 8'h86; img[543*8 +: 8] = 8'h66;
    return img;
  endfunction

  function automatic logic [SDEPTH*8-1:0] build_small();
    logic [SDEPTH*8-1:0] img;
    img = '0;
    img[0*8 +: 8] = 8'h83; img[1*8 +: 8] = 8'h33;
    img[2*8 +: 8] = 8'h89; img[3*8 +: 8] = 8'h99;
    img[4*8 +: 8] = 8'h40; img[5*8 +: 8] = 8'd20;
    return img;
  endfunction

  localparam logic [DEPTH*8-1:0]  MAIN_IMG  = build_main();
  localparam logic [SDEPTH*8-1:0] SMALL_IMG = build_small();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic recon = 1'b0;
  logic clr = 1'b0;
  logic [7:0] ctrl, s_ctrl;
  logic [7:0] imm, s_imm;
  logic [9:0] pc;
  logic [3:0] s_pc;
  logic wt, s_wt, flag, s_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ring_useq #(.ROM_DEPTH(DEPTH), .CTRL_W(8), .ROM_IMAGE(MAIN_IMG)) dut_i (
    .clk(clk), .rst(rst), .recon_i(recon), .flag_clr_i(clr),
    .ctrl_o(ctrl), .imm_o(imm), .pc_o(pc), .wait_o(wt), .recon_flag_o(flag)
  );

  ring_useq #(.ROM_DEPTH(SDEPTH), .CTRL_W(8), .ROM_IMAGE(SMALL_IMG)) dut_s (
    .clk(clk), .rst(rst), .recon_i(1'b0), .flag_clr_i(1'b0),
    .ctrl_o(s_ctrl), .imm_o(s_imm), .pc_o(s_pc), .wait_o(s_wt), .recon_flag_o(s_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_P/4);
    cyc++;
  endtask

  task automatic adv_to(input int n);
    while (cyc < n) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R1 reset state
    chk("R1 pc", int'(pc), 0);
    chk("R1 ctrl", int'(ctrl), 0);
    chk("R1 imm", int'(imm), 0);
    chk("R1 wait", int'(wt), 0);
    chk("R1 flag", int'(flag), 0);
    rst = 1'b0;
    cyc = 0;

    // R2 R3 R4: eight actions, selects 0..7
    for (int k = 0; k < 8; k++) begin
      adv_to(2*k + 1);
      chk("R2 pc opcode phase", int'(pc), 2*k + 1);
      chk("R4 ctrl idle", int'(ctrl), 0);
      adv_to(2*k + 2);
      chk("R2 pc imm phase", int'(pc), 2*k + 2);
      chk("R4 ctrl bit", int'(ctrl), 1 << k);
      chk("R4 imm", int'(imm), 16 + k);
      if (k == 0) begin
        chk("R4 small sel3", int'(s_ctrl), 8);
      end
      if (k == 1) begin
        chk("R4 small sel beyond width", int'(s_ctrl), 0);
        chk("R4 small imm", int'(s_imm), 8'h99);
      end
      if (k == 2) begin
        chk("R7 small jump beyond depth", int'(s_pc), 0);
      end
    end

    // R5 wait N=0 gives one period
    adv_to(18);
    chk("R5 wait0 pc", int'(pc), 18);
    chk("R5 wait0 flag", int'(wt), 1);
    adv_to(19);
    chk("R5 wait0 hold", int'(pc), 18);
    chk("R5 wait0 ctrl", int'(ctrl), 0);
    adv_to(20);
    chk("R5 wait0 end", int'(wt), 0);
    chk("R5 wait0 pc end", int'(pc), 18);
    adv_to(21);
    chk("R5 resume", int'(pc), 19);

    // R5 wait N=3 gives three periods
    for (int c = 22; c < 28; c++) begin
      adv_to(c);
      chk("R5 wait3 busy", int'(wt), 1);
      chk("R5 wait3 pc", int'(pc), 20);
      chk("R5 wait3 ctrl", int'(ctrl), 0);
    end
    adv_to(28);
    chk("R5 wait3 end", int'(wt), 0);

    // R6 jump to 540
    adv_to(29);
    chk("R3 jump opcode fetch", int'(pc), 21);
    adv_to(30);
    chk("R6 jump target", int'(pc), 540);
    adv_to(32);
    chk("R6 action at target", int'(ctrl), 128);
    chk("R6 imm at target", int'(imm), 8'h77);
    adv_to(34);
    chk("R8 wrap", int'(pc), 0);
    chk("R8 last action", int'(ctrl), 64);
    adv_to(36);
    chk("R8 second pass", int'(ctrl), 1);

    // R9 interrupt during the three-period wait of the second pass
    adv_to(57);
    chk("R9 pre wait", int'(wt), 1);
    recon = 1'b1;
    step();
    recon = 1'b0;
    chk("R9 pc zero", int'(pc), 0);
    chk("R9 flag set", int'(flag), 1);
    chk("R9 wait cancelled", int'(wt), 0);
    chk("R9 ctrl quiet", int'(ctrl), 0);
    step();
    chk("R9 opcode fetch", int'(pc), 1);
    step();
    chk("R9 restart action", int'(ctrl), 1);
    chk("R10 flag held", int'(flag), 1);

    // R10 clear and set-wins
    clr = 1'b1;
    step();
    clr = 1'b0;
    chk("R10 cleared", int'(flag), 0);
    recon = 1'b1; clr = 1'b1;
    step();
    recon = 1'b0; clr = 1'b0;
    chk("R10 set wins", int'(flag), 1);
    chk("R9 pc again", int'(pc), 0);
    clr = 1'b1;
    step();
    clr = 1'b0;
    chk("R10 cleared again", int'(flag), 0);
    recon = 1'b1;
    step();
    recon = 1'b0;

    // R1 reset mid-run
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1 flag after reset", int'(flag), 0);
    chk("R1 pc after reset", int'(pc), 0);
    chk("R1 imm after reset", int'(imm), 0);
    step();
    chk("R1 first fetch", int'(pc), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule